// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block runs a whole I2C master transaction from one 32-bit command word. The word says whether the bus is claimed with a START first, whether a STOP ends the transaction, whether SCL stays low for a later command, which way the bytes flow, whether the final received byte is refused, and how many bytes move. Bytes travel through a 32-bit data word. The least significant byte of each word goes on the bus first. A data-request flag shows software or a DMA channel when the next word must be supplied or collected.

Toward the pads the engine talks to a bit-level phy through a request/strobe handshake. Each step is one of four operations: START, STOP, drive a bit, or sample a bit. The phy answers each step with a done strobe and the SDA level it sampled. A write is one command whose first streamed byte is the address. A read is a one-byte address transmit with START and clock retention, followed by a receive command that continues the same bus ownership.

Top module: `i2c_cmd_engine`

## Requirements
- R1: A command write is accepted only while the engine is idle and only when bit 29 (run) and bit 17 (master) are both set. Any other command word leaves every output unchanged and produces no phy activity.
- R2: Command bit 19 issues a START (phy op 1) before the first byte. Bit 20 issues a STOP (phy op 2) after the last byte. Each condition is omitted when its bit is clear. Data bits use phy op 3 (drive `phy_bit`) and phy op 4 (sample `phy_rx`).
- R3: When bit 21 is set and the command ends without a STOP, `scl_hold` is 1 after completion. A newly accepted command clears it.
- R4: Bit 16 set selects transmit, and bits 15:0 give the byte count including the address byte. Bytes go out from bit 0 of each word upward, each byte MSB first. A partial final word holds its bytes in the low positions.
- R5: `dreq` rises when transmit needs a new word or when receive has a word ready in `rd_word`. It stays high until `dreq_clr`. Receive waits for that clear before it takes more bytes.
- R6: Received byte k lands in bits 8*(k mod 4)+7 down to 8*(k mod 4) of its word. A partial final word has zeros in its unused upper bytes.
- R7: On receive with bit 25 set, the master answers the final byte with NAK (1) and every earlier byte with ACK (0). With bit 25 clear, every byte is acknowledged.
- R8: `done` rises once the count is exhausted and the closing STOP or held state is reached. At that point `busy` is 0. `done` clears on `done_clr` or on a new command.
- R9: A NAK from the slave after any transmitted byte sets `nak_flag`. The engine then moves no further bytes, issues a STOP whatever bit 20 says, and sets `done`.
- R10: If the master drives a data bit of 1 and samples 0, `arb_lost` is set. The engine stops at once with no STOP, clears `bus_owned` and sets `done`.
- R11: A count of zero runs only the requested START and STOP and then sets `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 32 | Command word |
| data_wr | input | 1 | Transmit data word write strobe |
| data_wdata | input | 32 | Transmit data word |
| dreq_clr | input | 1 | Clears the data-request flag |
| done_clr | input | 1 | Clears the completion flag |
| rd_word | output | 32 | Last received data word |
| dreq | output | 1 | Data-request flag |
| done | output | 1 | Completion flag |
| nak_flag | output | 1 | Slave refused a byte |
| arb_lost | output | 1 | Arbitration lost |
| busy | output | 1 | Command in progress |
| scl_hold | output | 1 | Clock held low after completion |
| bus_owned | output | 1 | Bus claimed by this master |
| phy_req | output | 1 | Phy operation requested |
| phy_op | output | 3 | Phy operation code |
| phy_bit | output | 1 | Bit to drive for op 3 |
| phy_done | input | 1 | Phy operation complete strobe |
| phy_rx | input | 1 | SDA level sampled by the phy |

## Verification
The in-module assertions check several rules on every cycle. The remaining byte count never rises during a command. The data-request flag is raised only by an active command. Completion always coincides with an idle engine. A slave NAK is followed directly by a STOP request. Arbitration loss always leaves the bus released and the command finished. Byte order within words, zero fill of partial receive words, the ACK/NAK pattern, START and STOP placement, and clock retention across a select/read pair depend on whole transactions. Only the bench's slave model, which logs every bit on the phy handshake, can show these.

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine #(
  parameter int DW   = 32,
  parameter int CNTW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [31:0]   cmd_word,
  input  logic          data_wr,
  input  logic [DW-1:0] data_wdata,
  input  logic          dreq_clr,
  input  logic          done_clr,
  output logic [DW-1:0] rd_word,
  output logic          dreq,
  output logic          done,
  output logic          nak_flag,
  output logic          arb_lost,
  output logic          busy,
  output logic          scl_hold,
  output logic          bus_owned,
  output logic          phy_req,
  output logic [2:0]    phy_op,
  output logic          phy_bit,
  input  logic          phy_done,
  input  logic          phy_rx
);
  localparam int BPW = DW / 8;
  localparam int BIW = $clog2(BPW);
  localparam int B_RUN = 29, B_NAKL = 25, B_RET = 21, B_STOP = 20;
  localparam int B_START = 19, B_MAST = 17, B_DIR = 16;
  localparam logic [2:0] OP_NONE = 3'd0, OP_START = 3'd1, OP_STOP = 3'd2;
  localparam logic [2:0] OP_WR = 3'd3, OP_RD = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_NEXT, S_LOAD, S_BIT, S_ACK, S_RWAIT, S_FIN, S_STOP
  } st_t;

  st_t             st;
  logic            tx_f, nakl_f, ret_f, stop_f;
  logic [CNTW-1:0] cnt;
  logic [BIW-1:0]  bidx;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic [DW-1:0]   word;
  logic            last_byte;
  logic            unused_bits;

  assign unused_bits = ^{cmd_word[31:30], cmd_word[28:26], cmd_word[24:22], cmd_word[18]};
  assign busy      = (st != S_IDLE);
  assign last_byte = (cnt == CNTW'(1));
  assign phy_req   = (st == S_START) || (st == S_BIT) || (st == S_ACK) || (st == S_STOP);

  always_comb begin
    phy_op  = OP_NONE;
    phy_bit = 1'b1;
    case (st)
      S_START: phy_op = OP_START;
      S_STOP:  phy_op = OP_STOP;
      S_BIT: begin
        phy_op = tx_f ? OP_WR : OP_RD;
        if (tx_f) phy_bit = sh[7];
      end
      S_ACK: begin
        phy_op = tx_f ? OP_RD : OP_WR;
        if (!tx_f) phy_bit = last_byte & nakl_f;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tx_f <= 1'b0; nakl_f <= 1'b0; ret_f <= 1'b0; stop_f <= 1'b0;
      cnt <= '0; bidx <= '0; bitn <= '0; sh <= '0; word <= '0;
      rd_word <= '0; dreq <= 1'b0; done <= 1'b0; nak_flag <= 1'b0;
      arb_lost <= 1'b0; scl_hold <= 1'b0; bus_owned <= 1'b0;
    end else begin
      if (dreq_clr) dreq <= 1'b0;
      if (done_clr) done <= 1'b0;
      case (st)
        S_IDLE: if (cmd_wr && cmd_word[B_RUN] && cmd_word[B_MAST]) begin
          tx_f     <= cmd_word[B_DIR];
          nakl_f   <= cmd_word[B_NAKL];
          ret_f    <= cmd_word[B_RET];
          stop_f   <= cmd_word[B_STOP];
          cnt      <= cmd_word[CNTW-1:0];
          bidx     <= '0;
          word     <= '0;
          done     <= 1'b0;
          nak_flag <= 1'b0;
          arb_lost <= 1'b0;
          scl_hold <= 1'b0;
          dreq     <= 1'b0;
          st       <= cmd_word[B_START] ? S_START : S_NEXT;
        end
        S_START: if (phy_done) begin
          bus_owned <= 1'b1;
          st        <= S_NEXT;
        end
        S_NEXT: begin
          if (cnt == '0) st <= S_FIN;
          else if (!tx_f) begin
            bitn <= 3'd7;
            st   <= S_BIT;
          end else if (bidx == '0) begin
            dreq <= 1'b1;
            st   <= S_LOAD;
          end else begin
            sh   <= word[7:0];
            word <= word >> 8;
            bitn <= 3'd7;
            st   <= S_BIT;
          end
        end
        S_LOAD: if (data_wr) begin
          sh   <= data_wdata[7:0];
          word <= data_wdata >> 8;
          bitn <= 3'd7;
          st   <= S_BIT;
        end
        S_BIT: if (phy_done) begin
          if (tx_f) begin
            if (sh[7] && !phy_rx) begin
              arb_lost  <= 1'b1;
              bus_owned <= 1'b0;
              done      <= 1'b1;
              st        <= S_IDLE;
            end else begin
              sh <= {sh[6:0], 1'b0};
              if (bitn == 3'd0) st <= S_ACK;
              else bitn <= bitn - 3'd1;
            end
          end else begin
            sh <= {sh[6:0], phy_rx};
            if (bitn == 3'd0) begin
              word[{bidx, 3'b000} +: 8] <= {sh[6:0], phy_rx};
              st <= S_ACK;
            end else bitn <= bitn - 3'd1;
          end
        end
        S_ACK: if (phy_done) begin
          cnt  <= cnt - CNTW'(1);
          bidx <= bidx + BIW'(1);
          if (tx_f) begin
            if (phy_rx) begin
              nak_flag <= 1'b1;
              st       <= S_STOP;
            end else st <= S_NEXT;
          end else begin
            st <= S_NEXT;
            if (bidx == BIW'(BPW - 1) || last_byte) begin
              rd_word <= word;
              word    <= '0;
              dreq    <= 1'b1;
              if (!last_byte) st <= S_RWAIT;
            end
          end
        end
        S_RWAIT: if (!dreq) st <= S_NEXT;
        S_FIN: begin
          if (stop_f) st <= S_STOP;
          else begin
            scl_hold <= ret_f;
            done     <= 1'b1;
            st       <= S_IDLE;
          end
        end
        S_STOP: if (phy_done) begin
          bus_owned <= 1'b0;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (cnt <= $past(cnt)));

  // R5
  dreq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dreq) |-> $past(busy));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy);

  // R9
  nak_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_flag) |-> (phy_req && phy_op == OP_STOP));

  // R10
  arb_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_lost) |-> (done && !bus_owned && !busy));
endmodule

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;
  logic        clk = 0, rst_n = 0;
  logic        cmd_wr = 0, data_wr = 0, dreq_clr = 0, done_clr = 0;
  logic [31:0] cmd_word = 0, data_wdata = 0, rd_word;
  logic        dreq, done, nak_flag, arb_lost, busy, scl_hold, bus_owned;
  logic        phy_req, phy_bit, phy_done = 0, phy_rx = 1;
  logic [2:0]  phy_op;

  i2c_cmd_engine dut (.*);

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0;
  logic [7:0] wlog[64];
  logic [7:0] txb[16];
  logic [7:0] sd[16];
  logic       mack[64];
  logic [31:0] rw[8];
  int wcnt, macnt, rcnt, nstart, nstop, bitpos, dly, nak_at, nrw;
  bit arb_arm;
  logic [7:0] cur;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit st, input bit sp, input bit ret,
                                     input bit tx, input bit nl, input int n);
    return (32'd1 << 29) | (32'(nl) << 25) | (32'(ret) << 21) | (32'(sp) << 20) |
           (32'(st) << 19) | (32'd1 << 17) | (32'(tx) << 16) | 32'(n[15:0]);
  endfunction

  function automatic logic [31:0] pack_rx(input int j, input int m);
    logic [31:0] w = 0;
    for (int k = 0; k < 4; k++)
      if (4*j + k < m) w[8*k +: 8] = sd[4*j + k];
    return w;
  endfunction

  task automatic clr_log();
    wcnt = 0; macnt = 0; rcnt = 0; nstart = 0; nstop = 0; nak_at = -1; arb_arm = 0;
  endtask

  initial begin
    dly = 0; bitpos = 0; cur = 0;
    forever begin
      @(negedge clk);
      if (phy_done) phy_done = 0;
      else if (phy_req) begin
        if (dly > 0) dly--;
        else begin
          case (phy_op)
            3'd1: begin nstart++; bitpos = 0; phy_rx = 1; end
            3'd2: begin nstop++; phy_rx = 1; end
            3'd3: begin
              if (bitpos < 8) begin
                cur = {cur[6:0], phy_bit};
                phy_rx = phy_bit;
                if (arb_arm && phy_bit) begin phy_rx = 0; arb_arm = 0; end
                if (bitpos == 7) begin wlog[wcnt] = cur; wcnt++; end
              end else begin
                mack[macnt] = phy_bit; macnt++;
              end
              bitpos = (bitpos + 1) % 9;
            end
            3'd4: begin
              if (bitpos < 8) begin
                phy_rx = sd[rcnt][7 - bitpos];
                if (bitpos == 7) rcnt++;
              end else phy_rx = (nak_at >= 0 && wcnt - 1 == nak_at);
              bitpos = (bitpos + 1) % 9;
            end
            default: phy_rx = 1;
          endcase
          phy_done = 1;
          dly = $urandom % 3;
        end
      end
    end
  end

  task automatic send_cmd(input logic [31:0] c);
    @(negedge clk); cmd_word = c; cmd_wr = 1;
    @(negedge clk); cmd_wr = 0;
  endtask

  task automatic run_tx(input int n);
    int idx = 0;
    forever begin
      @(negedge clk);
      if (dreq) begin
        logic [31:0] w = 0;
        for (int k = 0; k < 4; k++)
          if (idx + k < n) w[8*k +: 8] = txb[idx + k];
        idx += 4;
        data_wdata = w; data_wr = 1; dreq_clr = 1;
        @(negedge clk); data_wr = 0; dreq_clr = 0;
      end else if (done) break;
    end
  endtask

  task automatic run_rx();
    nrw = 0;
    forever begin
      @(negedge clk);
      if (dreq) begin
        rw[nrw] = rd_word; nrw++;
        dreq_clr = 1;
        @(negedge clk); dreq_clr = 0;
      end else if (done) break;
    end
  endtask

  task automatic do_write(input int plen, input bit stp);
    clr_log();
    txb[0] = {7'($urandom), 1'b0};
    for (int i = 1; i <= plen; i++) txb[i] = 8'($urandom);
    send_cmd(mk(1, stp, 0, 1, 0, plen + 1));
    run_tx(plen + 1);
    chk("R4 byte count", wcnt, plen + 1);
    for (int i = 0; i <= plen; i++) chk("R4 tx byte order", wlog[i], txb[i]);
    chk("R2 start count", nstart, 1);
    chk("R2 stop count", nstop, stp ? 1 : 0);
    chk("R8 done", {done, busy}, 2'b10);
    chk("R9 no nak", nak_flag, 0);
  endtask

  task automatic do_read(input int m, input bit nl);
    clr_log();
    for (int i = 0; i < m; i++) sd[i] = 8'($urandom);
    txb[0] = {7'($urandom), 1'b1};
    send_cmd(mk(1, 0, 1, 1, 0, 1));
    run_tx(1);
    chk("R3 clock held after select", scl_hold, 1);
    chk("R2 no stop after select", nstop, 0);
    chk("R8 select done", done, 1);
    send_cmd(mk(0, 1, 0, 0, nl, m));
    chk("R3 hold cleared by new command", scl_hold, 0);
    run_rx();
    chk("R5 rx word count", nrw, (m + 3) / 4);
    for (int j = 0; j < (m + 3) / 4; j++) chk("R6 rx word packing", rw[j], pack_rx(j, m));
    chk("R7 ack count", macnt, m);
    for (int i = 0; i < m; i++)
      chk("R7 master ack bit", mack[i], (i == m - 1) ? nl : 1'b0);
    chk("R2 single start", nstart, 1);
    chk("R2 stop after read", nstop, 1);
    chk("R8 read done", {done, bus_owned}, 2'b10);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    clr_log();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R8 reset state", {busy, done, dreq, nak_flag, arb_lost, scl_hold, bus_owned, phy_req},
        8'h00);

    // R1: run bit clear, then master bit clear
    send_cmd(mk(1, 1, 0, 1, 0, 3) & ~(32'd1 << 29));
    send_cmd(mk(1, 1, 0, 1, 0, 3) & ~(32'd1 << 17));
    repeat (4) @(negedge clk);
    chk("R1 ignored command", {busy, phy_req, dreq, done}, 4'b0000);
    chk("R1 no phy activity", nstart, 0);

    // directed partial-word boundaries
    do_write(2, 1);
    do_write(3, 1);
    do_write(4, 0);
    chk("R2 bus still owned without stop", bus_owned, 1);
    chk("R3 no hold without retain", scl_hold, 0);
    do_read(1, 1);
    do_read(4, 1);
    do_read(5, 0);

    // R11: zero count
    clr_log();
    send_cmd(mk(1, 1, 0, 1, 0, 0));
    run_tx(0);
    chk("R11 zero count start/stop", {nstart[3:0], nstop[3:0]}, 8'h11);
    chk("R11 zero count no bytes", wcnt, 0);
    chk("R11 zero count done", done, 1);

    // R9: address NAK with stop flag clear
    clr_log();
    nak_at = 0;
    txb[0] = 8'hA4; txb[1] = 8'h11; txb[2] = 8'h22;
    send_cmd(mk(1, 0, 0, 1, 0, 3));
    run_tx(3);
    chk("R9 nak flag on address", nak_flag, 1);
    chk("R9 one byte only", wcnt, 1);
    chk("R9 forced stop", nstop, 1);
    chk("R9 done and released", {done, bus_owned}, 2'b10);

    // R9: data byte NAK
    clr_log();
    nak_at = 2;
    for (int i = 0; i < 7; i++) txb[i] = 8'(8'h30 + i);
    send_cmd(mk(1, 1, 0, 1, 0, 7));
    run_tx(7);
    chk("R9 nak flag on data", nak_flag, 1);
    chk("R9 bytes stop at nak", wcnt, 3);
    chk("R9 stop once", nstop, 1);

    // R10: arbitration loss
    clr_log();
    arb_arm = 1;
    txb[0] = 8'h5A; txb[1] = 8'hFF;
    send_cmd(mk(1, 1, 0, 1, 0, 2));
    run_tx(2);
    chk("R10 arb flag", arb_lost, 1);
    chk("R10 no stop", nstop, 0);
    chk("R10 released and done", {done, bus_owned, busy}, 3'b100);

    // R8: done_clr
    @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
    chk("R8 done cleared", done, 0);

    // random mix
    for (int it = 0; it < 8; it++) begin
      do_write(1 + int'($urandom % 10), 1);
      do_read(1 + int'($urandom % 12), 1'($urandom));
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule